// File: doc/BRIEF.md
# Byte-Lane Random Port with Command Register

This block is the random-access side of a 4096-word by 16-bit memory, rebuilt as a synchronous design. A word is split into a lower and an upper byte lane. Each lane has its own active-low enable, so reads and writes can cover one lane or both. With the chip select active and the command select inactive, the port reads and writes the memory array. With the chip select inactive and the command select active, the same data bus reaches a small command register instead. That register is 12 bits wide when written. When read back it is 13 bits wide, because a status bit from the sequential side is placed on top.

Real tri-state pins are replaced by per-lane drive enables and a read-valid flag, which keeps the block synthesizable. Every operation is sampled on the rising clock edge, and its read result appears on the registered outputs one cycle later. The command register is meant for the sequential port. If command select is used while the sequential port reports that it is busy, the access is blocked and a conflict flag is raised.

Top module: `byte_lane_port`

## Requirements
- R1: After reset, `lane_en` is 0, `rd_valid` is 0, `rdata` is 0, `conflict` is 0 and `cmd_reg` is 0.
- R2: When `ce_n` and `cmd_n` are both 1, there is no read output (`lane_en` is 0 the next cycle) and no write to the memory or the command register.
- R3: When `oe_n` is 1, a read cycle drives no lane (`lane_en` is 0 the next cycle). A write with `oe_n` at 1 still takes effect.
- R4: A memory read (`ce_n`=0, `cmd_n`=1, `rw_n`=1, `oe_n`=0) sets `lane_en` to {~ub_n, ~lb_n} one cycle later. `rdata[7:0]` then holds the low byte of the addressed word if `lb_n`=0, and `rdata[15:8]` holds the high byte if `ub_n`=0. A lane that is not enabled reads 0. `rd_valid` is high exactly when some lane is enabled.
- R5: A memory write (`ce_n`=0, `cmd_n`=1, `rw_n`=0) stores `wdata[7:0]` only if `lb_n`=0 and `wdata[15:8]` only if `ub_n`=0. The other lane of the word is kept.
- R6: A command write (`ce_n`=1, `cmd_n`=0, `rw_n`=0, `seq_busy`=0) loads `wdata[7:0]` into `cmd_reg[7:0]` if `lb_n`=0 and `wdata[11:8]` into `cmd_reg[11:8]` if `ub_n`=0. The new value shows on `cmd_reg` the next cycle, and `cmd_reg` changes at no other time.
- R7: A command read (`ce_n`=1, `cmd_n`=0, `rw_n`=1, `oe_n`=0, `seq_busy`=0) returns the word {3'b000, seq_status, cmd_reg} one cycle later. It is masked by lane in the same way as R4, so bits 15:13 are always 0.
- R8: With `ce_n`=0 and `cmd_n`=0 together, nothing is read or written.
- R9: A cycle with `cmd_n`=0 and `seq_busy`=1 performs no command access and sets `conflict` to 1 the next cycle. `conflict` is 0 after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip select for the memory array |
| cmd_n | input | 1 | Active-low command register select |
| rw_n | input | 1 | 1 = read, 0 = write |
| oe_n | input | 1 | Active-low output enable |
| lb_n | input | 1 | Active-low lower byte lane enable |
| ub_n | input | 1 | Active-low upper byte lane enable |
| addr | input | 12 | Word address |
| wdata | input | 16 | Write data |
| seq_status | input | 1 | Status bit from the sequential side, returned as readback bit 12 |
| seq_busy | input | 1 | Sequential port is operating |
| rdata | output | 16 | Registered read data, 0 on lanes that are not driven |
| lane_en | output | 2 | Per-lane drive enable, bit 1 upper, bit 0 lower |
| rd_valid | output | 1 | Some lane is driven |
| cmd_reg | output | 12 | Command register contents |
| conflict | output | 1 | Command select was used while the sequential port was busy |

## Verification
A wrong lane mask or decode shows up at the ports one cycle after the read. Either the wrong byte appears in `rdata`, or a lane is driven when the other lane or output enable forbade it. A bad write shows only later, when the word is read back, so every write is followed by reads of the same address under different lane patterns. Corruption of the command register is visible on `cmd_reg` in the very next cycle, and readback also exposes the placement of the status bit and the zeroed top bits.

// File: rtl/byte_lane_port.sv
module byte_lane_port #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          cmd_n,
  input  logic          rw_n,
  input  logic          oe_n,
  input  logic          lb_n,
  input  logic          ub_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          seq_status,
  input  logic          seq_busy,
  output logic [DW-1:0] rdata,
  output logic [1:0]    lane_en,
  output logic          rd_valid,
  output logic [CW-1:0] cmd_reg,
  output logic          conflict
);
  localparam int LW    = DW / 2;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  wire          mem_acc  = !ce_n && cmd_n;
  wire          cmd_acc  = ce_n && !cmd_n && !seq_busy;
  wire          rd_go    = rw_n && !oe_n && (mem_acc || cmd_acc);
  wire [1:0]    lane_req = ~{ub_n, lb_n};
  wire [DW-1:0] mask     = {{LW{lane_req[1]}}, {LW{lane_req[0]}}};
  wire [DW-1:0] cmd_word = DW'({seq_status, cmd_reg});

  always_ff @(posedge clk) begin
    if (mem_acc && !rw_n) begin
      if (lane_req[0]) mem[addr][LW-1:0]  <= wdata[LW-1:0];
      if (lane_req[1]) mem[addr][DW-1:LW] <= wdata[DW-1:LW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_reg  <= '0;
      rdata    <= '0;
      lane_en  <= '0;
      conflict <= 1'b0;
    end else begin
      if (cmd_acc && !rw_n) begin
        if (lane_req[0]) cmd_reg[LW-1:0]  <= wdata[LW-1:0];
        if (lane_req[1]) cmd_reg[CW-1:LW] <= wdata[CW-1:LW];
      end
      lane_en  <= rd_go ? lane_req : 2'b00;
      rdata    <= rd_go ? ((mem_acc ? mem[addr] : cmd_word) & mask) : '0;
      conflict <= !cmd_n && seq_busy;
    end
  end

  assign rd_valid = |lane_en;

  a_r2_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && cmd_n) |=> (lane_en == 2'b00));
  a_r3_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> (lane_en == 2'b00));
  a_r4_lane_subset: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lane_en & $past({ub_n, lb_n})) == 2'b00));
  a_r6_creg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ce_n && !cmd_n && !rw_n) |=> $stable(cmd_reg));
  a_r7_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !cmd_n) |=> (rdata[DW-1:CW+1] == '0));
  a_r8_both_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !cmd_n) |=> (lane_en == 2'b00 && $stable(cmd_reg)));
  a_r9_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_n && seq_busy) |=> (conflict && $stable(cmd_reg)));
endmodule

// File: tb/test_byte_lane_port.sv
module test_byte_lane_port;
  logic clk = 0, rst_n = 0;
  logic ce_n = 1, cmd_n = 1, rw_n = 1, oe_n = 1, lb_n = 1, ub_n = 1;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic seq_status = 0, seq_busy = 0;
  logic [15:0] rdata;
  logic [1:0]  lane_en;
  logic        rd_valid, conflict;
  logic [11:0] cmd_reg;

  byte_lane_port i_byte_lane_port (.clk, .rst_n, .ce_n, .cmd_n, .rw_n, .oe_n,
    .lb_n, .ub_n, .addr, .wdata, .seq_status, .seq_busy, .rdata, .lane_en,
    .rd_valid, .cmd_reg, .conflict);

  always #10 clk = ~clk;

  typedef struct {
    logic [1:0]  lanes;
    logic [15:0] data;
    logic        confl;
    logic [11:0] creg;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0, cycles = 0;
  logic [15:0] mdl_mem [4096];
  logic [11:0] mdl_creg = '0;

  task automatic op(input logic ce, cmd, rw, oe, lb, ub, input logic [11:0] a,
                    input logic [15:0] d, input logic st, bsy, input string tag);
    exp_t e;
    logic mem_acc, cmd_acc;
    logic [1:0] ln;
    logic [15:0] w, m;
    @(negedge clk);
    ce_n = ce; cmd_n = cmd; rw_n = rw; oe_n = oe; lb_n = lb; ub_n = ub;
    addr = a; wdata = d; seq_status = st; seq_busy = bsy;
    mem_acc = !ce && cmd;
    cmd_acc = ce && !cmd && !bsy;
    ln = ~{ub, lb};
    m = {{8{ln[1]}}, {8{ln[0]}}};
    w = mem_acc ? mdl_mem[a] : {3'b000, st, mdl_creg};
    e.lanes = (rw && !oe && (mem_acc || cmd_acc)) ? ln : 2'b00;
    e.data  = (e.lanes != 0) ? (w & m) : 16'h0;
    e.confl = !cmd && bsy;
    if (!rw && mem_acc) mdl_mem[a] = (mdl_mem[a] & ~m) | (d & m);
    if (!rw && cmd_acc) mdl_creg = (mdl_creg & ~m[11:0]) | (d[11:0] & m[11:0]);
    e.creg = mdl_creg;
    e.tag  = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (lane_en !== e.lanes || rdata !== e.data || conflict !== e.confl ||
          cmd_reg !== e.creg || rd_valid !== (|e.lanes)) begin
        fails++;
        $display("FAIL %s: got lanes=%b data=%h confl=%b creg=%h valid=%b, expected lanes=%b data=%h confl=%b creg=%h valid=%b",
                 e.tag, lane_en, rdata, conflict, cmd_reg, rd_valid,
                 e.lanes, e.data, e.confl, e.creg, |e.lanes);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog: got %0d cycles, expected fewer", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4096; i++) mdl_mem[i] = 'x;
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (lane_en !== 0 || rdata !== 0 || rd_valid !== 0 || conflict !== 0 || cmd_reg !== 0) begin
      fails++;
      $display("FAIL R1 reset: got lanes=%b data=%h valid=%b confl=%b creg=%h, expected all zero",
               lane_en, rdata, rd_valid, conflict, cmd_reg);
    end
    @(negedge clk) rst_n = 1;
    // ce, cmd, rw, oe, lb, ub
    op(0,1,0,1,0,0, 12'h010, 16'hA1B2, 0,0, "R5 full write oe high (R3)");
    op(0,1,0,0,0,0, 12'hFFF, 16'h1234, 0,0, "R5 full write top addr");
    op(0,1,1,0,0,0, 12'h010, 16'h0,    0,0, "R4 read both");
    op(0,1,1,0,0,1, 12'h010, 16'h0,    0,0, "R4 read low only");
    op(0,1,1,0,1,0, 12'hFFF, 16'h0,    0,0, "R4 read high only");
    op(0,1,1,0,1,1, 12'h010, 16'h0,    0,0, "R4 read no lane");
    op(0,1,1,1,0,0, 12'h010, 16'h0,    0,0, "R3 read oe high");
    op(0,1,0,0,0,1, 12'h010, 16'hFF77, 0,0, "R5 low lane write");
    op(0,1,0,0,1,0, 12'hFFF, 16'h99EE, 0,0, "R5 high lane write");
    op(0,1,1,0,0,0, 12'h010, 16'h0,    0,0, "R5 readback low lane");
    op(0,1,1,0,0,0, 12'hFFF, 16'h0,    0,0, "R5 readback high lane");
    op(1,1,0,0,0,0, 12'h010, 16'hDEAD, 0,0, "R2 deselected write");
    op(1,1,1,0,0,0, 12'h010, 16'h0,    0,0, "R2 deselected read");
    op(0,1,1,0,0,0, 12'h010, 16'h0,    0,0, "R2 word unchanged");
    op(0,0,0,0,0,0, 12'h010, 16'h5555, 0,0, "R8 both selects write");
    op(0,0,1,0,0,0, 12'h010, 16'h0,    0,0, "R8 both selects read");
    op(0,1,1,0,0,0, 12'h010, 16'h0,    0,0, "R8 word unchanged");
    op(1,0,0,0,0,0, 12'h000, 16'hFABC, 0,0, "R6 cmd write both");
    op(1,0,1,0,0,0, 12'h000, 16'h0,    1,0, "R7 cmd read status 1");
    op(1,0,1,0,0,0, 12'h000, 16'h0,    0,0, "R7 cmd read status 0");
    op(1,0,0,0,0,1, 12'h000, 16'h1122, 0,0, "R6 cmd write low");
    op(1,0,0,0,1,0, 12'h000, 16'hF3FF, 0,0, "R6 cmd write high");
    op(1,0,1,0,1,0, 12'h000, 16'h0,    1,0, "R7 cmd read high lane");
    op(1,0,1,1,0,0, 12'h000, 16'h0,    1,0, "R3 cmd read oe high");
    op(1,0,0,0,0,0, 12'h000, 16'h0777, 0,1, "R9 cmd write while busy");
    op(1,0,1,0,0,0, 12'h000, 16'h0,    1,1, "R9 cmd read while busy");
    op(1,1,1,0,0,0, 12'h000, 16'h0,    0,1, "R9 busy without cmd");
    op(1,0,1,0,0,0, 12'h000, 16'h0,    0,0, "R9 cmd value kept");
    op(1,1,1,1,1,1, 12'h000, 16'h0,    0,0, "R2 idle");
    repeat (3) @(posedge clk);
    #8;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule